// File: doc/BRIEF.md
# Paged Presence-Detect EEPROM Target

This block is the target side of a two-wire (I2C/SMBus) link that stands in for the identification memory on a plug-in memory module. It holds 512 bytes in plain registers. The bytes are arranged as two 256-byte pages, and each page is split into two 128-byte protection blocks. The host sees one 256-byte window at a time. It picks the window by addressing one of two fixed command addresses. These command addresses are shared by every module on the bus and do not depend on the slot pins.

The memory answers at a 7-bit address made of a fixed 4-bit type prefix followed by the three slot-select pins. Up to eight modules can therefore share one clock line and one data line. The block oversamples both lines on the system clock and detects START and STOP. It shifts bytes in and out, and it pulls the data line low only to acknowledge or to send a zero bit. It supports byte write, sequential write, random read (a write that sets the pointer, then a repeated START and a read) and sequential read. One 8-bit word pointer auto-increments for all of these.

Top module: `presence_eeprom_tgt`

## Requirements
- R1: The select byte is the 7-bit address followed by an R/W bit in bit 0 (0 = write, 1 = read). The memory address is prefix 4'b1010 followed by slot_i[2:0], giving 0x50..0x57. A matching select byte is acknowledged: sda_oe_o is high during the ninth clock.
- R2: A select byte that matches neither the memory address nor a page command gets no acknowledge. The target then keeps sda_oe_o low until the next START, so the following bytes are not acknowledged either.
- R3: A write transaction carries the select byte, then a word-pointer byte, then data bytes. Each data byte whose block is unprotected is stored at the pointer and acknowledged. The pointer then increments.
- R4: In a random read, the target first receives a write transaction that carries only the pointer byte. After a repeated START and a read select byte, it returns the byte stored at that pointer in the active page, MSB first.
- R5: In a sequential read, the pointer advances after every byte sent. A host acknowledge makes the target send the next byte. A host NACK ends the transfer, and the data line is released.
- R6: The pointer is 8 bits wide. When it passes 0xFF it wraps to 0x00 of the same page, for both reads and writes. The active page never changes because of this wrap.
- R7: A select byte with address 0x36 makes page 0 active, and address 0x37 makes page 1 active. This holds for any slot_i value and either R/W bit. The target acknowledges the select byte, NACKs every data byte that follows and ignores it. Those data bytes change neither the pointer nor the array.
- R8: After reset, page 0 is active and the data line is released.
- R9: The block index is {active page, pointer bit 7}, and wp_blk_i[index] = 1 protects that block. A data byte aimed at a protected block is NACKed and leaves the array unchanged. The pointer still increments.
- R10: A START seen at any point aborts the transfer in progress and releases the line. A STOP returns the target to idle with the line released. The pointer and the page are kept across both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND result) |
| slot_i | input | 3 | Slot-select pins, the low bits of the memory address |
| wp_blk_i | input | 4 | Write-protect flag per 128-byte block, indexed {page, pointer bit 7} |
| sda_oe_o | output | 1 | When high, the data line is pulled low |

## Verification
Two actions can fall on the same data byte: the protection check that refuses a store, and the pointer step that still takes place. To provoke both, the bench runs one sequential write from address 0x7F to 0x80 of page 1, with only the lower block of that page protected. It then expects a NACK followed by an ACK. Reading both addresses back must give the old value at 0x7F and the new value at 0x80. A second clash is the pointer wrap during a sequential read: the bench reads across 0xFF and expects the next byte to come from 0x00 of the same page, not from the other page.

// File: rtl/pd_pkg.sv
package pd_pkg;
    localparam int WORD_W    = 8;                   // word pointer width
    localparam int PAGE_W    = 1;                   // two pages
    localparam int BLKSEL_W  = 1;                   // two blocks per page
    localparam int MEM_AW    = PAGE_W + WORD_W;
    localparam int NUM_BLKS  = 1 << (PAGE_W + BLKSEL_W);
    localparam int SLOT_W    = 3;
    localparam int CNT_W     = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        CX_SEL,
        CX_WORD,
        CX_WDATA,
        CX_PAGE
    } ctx_e;

    typedef struct packed {
        phase_e              phase;
        ctx_e                ctx;
        logic [CNT_W-1:0]    cnt;
        logic [WORD_W-1:0]   shreg;
        logic [WORD_W-1:0]   ptr;
        logic [PAGE_W-1:0]   page;
        logic                oe;
        logic                to_tx;
        logic                mack;
    } tgt_state_t;
endpackage

// File: rtl/pd_bus_sampler.sv
module pd_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic [STAGES-1:0] scl_sh_d, sda_sh_d;
    logic              scl_p_q, sda_p_q;
    logic              scl_c;

    always_comb begin
        scl_sh_d = {scl_sh_q[STAGES-2:0], scl_i};
        sda_sh_d = {sda_sh_q[STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_c    = scl_sh_q[STAGES-1];
    assign sda_s    = sda_sh_q[STAGES-1];
    assign scl_rise = scl_c & ~scl_p_q;
    assign scl_fall = ~scl_c & scl_p_q;
    assign start_ev = scl_c & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_c & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/pd_addr_match.sv
module pd_addr_match #(
    parameter logic [3:0] MEM_PREFIX = 4'b1010,
    parameter logic [6:0] PAGE_BASE  = 7'h36,
    parameter int         SLOT_W     = 3
) (
    input  logic [7:0]        sel_byte,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              mem_hit,
    output logic              page_hit,
    output logic              page_sel,
    output logic              rd
);
    logic [6:0] dev_addr;

    always_comb begin
        dev_addr = sel_byte[7:1];
        rd       = sel_byte[0];
        mem_hit  = (dev_addr == {MEM_PREFIX, slot_i});
        // the two page commands differ only in the address LSB
        page_hit = (dev_addr[6:1] == PAGE_BASE[6:1]);
        page_sel = dev_addr[0];
    end
endmodule

// File: rtl/pd_mem.sv
module pd_mem #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr_q[i] <= '0;
        end else if (we) begin
            arr_q[waddr] <= wdata;
        end
    end

    assign rdata = arr_q[raddr];
endmodule

// File: rtl/presence_eeprom_tgt.sv
module presence_eeprom_tgt
    import pd_pkg::*;
#(
    parameter logic [3:0] MEM_PREFIX  = 4'b1010,
    parameter logic [6:0] PAGE_BASE   = 7'h36,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [SLOT_W-1:0]   slot_i,
    input  logic [NUM_BLKS-1:0] wp_blk_i,
    output logic                sda_oe_o
);
    localparam logic [WORD_W-1:0] PTR_ONE = WORD_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    tgt_state_t s_q, s_d;

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic mem_hit, page_hit, page_sel, sel_rd;
    logic mem_we;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [PAGE_W+BLKSEL_W-1:0] blk_idx;

    // observation nets for the bound checker
    logic              st_idle, tx_active;
    logic [WORD_W-1:0] ptr_now;
    logic [PAGE_W-1:0] page_now;

    pd_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    pd_addr_match #(
        .MEM_PREFIX (MEM_PREFIX),
        .PAGE_BASE  (PAGE_BASE),
        .SLOT_W     (SLOT_W)
    ) u_match (
        .sel_byte (s_q.shreg),
        .slot_i   (slot_i),
        .mem_hit  (mem_hit),
        .page_hit (page_hit),
        .page_sel (page_sel),
        .rd       (sel_rd)
    );

    pd_mem #(.AW(MEM_AW), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign mem_raddr = {s_q.page, s_q.ptr};
    assign blk_idx   = {s_q.page, s_q.ptr[WORD_W-1 -: BLKSEL_W]};

    always_comb begin
        s_d       = s_q;
        mem_we    = 1'b0;
        mem_waddr = {s_q.page, s_q.ptr};
        mem_wdata = s_q.shreg;

        if (start_ev) begin
            s_d.phase = PH_RX;
            s_d.ctx   = CX_SEL;
            s_d.cnt   = '0;
            s_d.oe    = 1'b0;
        end else if (stop_ev) begin
            s_d.phase = PH_IDLE;
            s_d.oe    = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_RX: begin
                    if (scl_rise && s_q.cnt < CNT_W'(8)) begin
                        s_d.shreg = {s_q.shreg[WORD_W-2:0], sda_s};
                        s_d.cnt   = s_q.cnt + CNT_ONE;
                    end
                    if (scl_fall && s_q.cnt == CNT_W'(8)) begin
                        s_d.cnt   = '0;
                        s_d.phase = PH_ACK;
                        s_d.to_tx = 1'b0;
                        unique case (s_q.ctx)
                            CX_SEL: begin
                                if (mem_hit) begin
                                    s_d.oe = 1'b1;
                                    if (sel_rd) s_d.to_tx = 1'b1;
                                    else        s_d.ctx   = CX_WORD;
                                end else if (page_hit) begin
                                    s_d.oe   = 1'b1;
                                    s_d.page = page_sel;
                                    s_d.ctx  = CX_PAGE;
                                end else begin
                                    s_d.phase = PH_IDLE;
                                end
                            end
                            CX_WORD: begin
                                s_d.ptr = s_q.shreg;
                                s_d.oe  = 1'b1;
                                s_d.ctx = CX_WDATA;
                            end
                            CX_WDATA: begin
                                if (!wp_blk_i[blk_idx]) begin
                                    mem_we = 1'b1;
                                    s_d.oe = 1'b1;
                                end
                                s_d.ptr = s_q.ptr + PTR_ONE;
                            end
                            default: begin
                                s_d.oe = 1'b0;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        if (s_q.to_tx) begin
                            s_d.shreg = mem_rdata;
                            s_d.ptr   = s_q.ptr + PTR_ONE;
                            s_d.cnt   = '0;
                            s_d.phase = PH_TX;
                            s_d.oe    = ~mem_rdata[WORD_W-1];
                        end else begin
                            s_d.oe    = 1'b0;
                            s_d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        s_d.shreg = {s_q.shreg[WORD_W-2:0], 1'b0};
                        s_d.cnt   = s_q.cnt + CNT_ONE;
                        if (s_q.cnt == CNT_W'(7)) begin
                            s_d.phase = PH_MACK;
                            s_d.oe    = 1'b0;
                            s_d.mack  = 1'b0;
                        end else begin
                            s_d.oe    = ~s_q.shreg[WORD_W-2];
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) s_d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (s_q.mack) begin
                            s_d.shreg = mem_rdata;
                            s_d.ptr   = s_q.ptr + PTR_ONE;
                            s_d.cnt   = '0;
                            s_d.phase = PH_TX;
                            s_d.oe    = ~mem_rdata[WORD_W-1];
                        end else begin
                            s_d.phase = PH_IDLE;
                            s_d.oe    = 1'b0;
                        end
                    end
                end
                default: begin
                    s_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, ctx: CX_SEL, cnt: '0, shreg: '0,
                     ptr: '0, page: '0, oe: 1'b0, to_tx: 1'b0, mack: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe_o  = s_q.oe;
    assign st_idle   = (s_q.phase == PH_IDLE);
    assign tx_active = (s_q.phase == PH_TX);
    assign ptr_now   = s_q.ptr;
    assign page_now  = s_q.page;
endmodule

// File: rtl/pd_checks.sv
module pd_checks
    import pd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sda_oe_o,
    input logic                start_ev,
    input logic                st_idle,
    input logic                tx_active,
    input logic                mem_we,
    input logic [MEM_AW-1:0]   mem_waddr,
    input logic [NUM_BLKS-1:0] wp_blk_i,
    input logic [WORD_W-1:0]   ptr_now,
    input logic [PAGE_W-1:0]   page_now
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !sda_oe_o); // R2

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe_o); // R10

    AST_PROTECTED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_blk_i[mem_waddr[MEM_AW-1 -: PAGE_W+1]]); // R9

    AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr_now == $past(ptr_now) + WORD_W'(1)); // R3

    AST_PAGE_HELD_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> $stable(page_now)); // R6
endmodule

bind presence_eeprom_tgt pd_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_o  (sda_oe_o),
    .start_ev  (start_ev),
    .st_idle   (st_idle),
    .tx_active (tx_active),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .wp_blk_i  (wp_blk_i),
    .ptr_now   (ptr_now),
    .page_now  (page_now)
);

// File: tb/presence_eeprom_tgt_tb.sv
module presence_eeprom_tgt_tb;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] slot = 3'd0;
    logic [3:0] wp = 4'd0;
    logic       sda_oe;
    logic       sda;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign sda = ~(m_low | sda_oe);

    presence_eeprom_tgt u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda),
        .slot_i   (slot),
        .wp_blk_i (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clk(input logic drv_low, output logic smp);
        wt(2);
        m_low = drv_low;
        wt(Q - 2);
        scl = 1'b1;
        wt(Q);
        smp = sda;
        wt(Q);
        scl = 1'b0;
        wt(Q);
    endtask

    task automatic b_start;
        m_low = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b1; wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic b_stop;
        m_low = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b0; wt(2 * Q);
    endtask

    task automatic b_wr(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(~b[i], s);
        bit_clk(1'b0, s);
        ack = ~s;
    endtask

    task automatic b_rd(input logic host_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_clk(1'b0, s);
            b = {b[6:0], s};
        end
        bit_clk(host_ack, s);
    endtask

    function automatic logic [7:0] mem_sel(input logic rd);
        return {4'hA, slot, rd};
    endfunction

    task automatic wr_two(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                          output logic a0, output logic a1);
        logic a;
        b_start;
        b_wr(mem_sel(1'b0), a);
        b_wr(p, a);
        b_wr(d0, a0);
        b_wr(d1, a1);
        b_stop;
    endtask

    task automatic wr_one(input logic [7:0] p, input logic [7:0] d0, output logic a0);
        logic a;
        b_start;
        b_wr(mem_sel(1'b0), a);
        b_wr(p, a);
        b_wr(d0, a0);
        b_stop;
    endtask

    task automatic rd_two(input logic [7:0] p, output logic [7:0] r0, output logic [7:0] r1);
        logic a;
        b_start;
        b_wr(mem_sel(1'b0), a);
        b_wr(p, a);
        b_start;
        b_wr(mem_sel(1'b1), a);
        b_rd(1'b1, r0);
        b_rd(1'b0, r1);
        b_stop;
    endtask

    task automatic page_cmd(input logic pg, output logic a_sel, output logic a_dat);
        b_start;
        b_wr({6'b011011, pg, 1'b0}, a_sel);
        b_wr(8'h00, a_dat);
        b_stop;
    endtask

    task automatic t_reset;
        chk(sda_oe == 1'b0, "R8 line released after reset", int'(sda_oe), 0);
    endtask

    task automatic t_slots;
        logic a, a2;
        for (int s = 0; s < 8; s++) begin
            slot = 3'(s);
            for (int t = 0; t < 8; t++) begin
                b_start;
                b_wr({4'hA, 3'(t), 1'b0}, a);
                if (t == s) begin
                    chk(a == 1'b1, "R1 own slot address acked", int'(a), 1);
                    b_stop;
                end else begin
                    chk(a == 1'b0, "R2 foreign address not acked", int'(a), 0);
                    b_wr(8'h00, a2);
                    chk(a2 == 1'b0, "R2 silent until next start", int'(a2), 0);
                    b_stop;
                end
            end
        end
    endtask

    task automatic t_write_read;
        logic a0, a1;
        logic [7:0] r0, r1;
        slot = 3'd2;
        wr_two(8'h10, 8'h5A, 8'hA5, a0, a1);
        chk(a0 && a1, "R3 data bytes acked", int'({a0, a1}), 3);
        rd_two(8'h10, r0, r1);
        chk(r0 == 8'h5A, "R4 random read", int'(r0), 'h5A);
        chk(r1 == 8'hA5, "R5 sequential read next byte", int'(r1), 'hA5);
        chk(sda_oe == 1'b0, "R5 released after host NACK", int'(sda_oe), 0);
        rd_two(8'h11, r0, r1);
        chk(r0 == 8'hA5, "R3 pointer advanced on write", int'(r0), 'hA5);
    endtask

    task automatic t_wrap;
        logic a0, a1;
        logic [7:0] r0, r1;
        wr_two(8'hFF, 8'h11, 8'h22, a0, a1);
        rd_two(8'hFF, r0, r1);
        chk(r0 == 8'h11, "R6 byte at 0xFF", int'(r0), 'h11);
        chk(r1 == 8'h22, "R6 wrap to 0x00 same page", int'(r1), 'h22);
    endtask

    task automatic t_pages;
        logic a0, a1;
        logic [7:0] r0, r1;
        wr_one(8'h20, 8'h77, a0);
        slot = 3'd5;
        page_cmd(1'b1, a0, a1);
        chk(a0 == 1'b1, "R7 page-1 command acked", int'(a0), 1);
        chk(a1 == 1'b0, "R7 page command data NACKed", int'(a1), 0);
        rd_two(8'h20, r0, r1);
        chk(r0 == 8'h00, "R8 page 0 was active before command", int'(r0), 0);
        wr_one(8'h20, 8'h99, a0);
        page_cmd(1'b0, a0, a1);
        chk(a0 == 1'b1, "R7 page-0 command acked", int'(a0), 1);
        rd_two(8'h20, r0, r1);
        chk(r0 == 8'h77, "R7 page 0 content", int'(r0), 'h77);
        chk(r1 == 8'h00, "R7 ignored data left array", int'(r1), 0);
        page_cmd(1'b1, a0, a1);
        rd_two(8'h20, r0, r1);
        chk(r0 == 8'h99, "R7 page 1 content", int'(r0), 'h99);
    endtask

    task automatic t_protect;
        logic a0, a1;
        logic [7:0] r0, r1;
        wp = 4'b0100;
        wr_two(8'h7F, 8'hE1, 8'hC4, a0, a1);
        chk(a0 == 1'b0, "R9 protected byte NACKed", int'(a0), 0);
        chk(a1 == 1'b1, "R9 pointer moved to open block", int'(a1), 1);
        rd_two(8'h7F, r0, r1);
        chk(r0 == 8'h00, "R9 protected byte unchanged", int'(r0), 0);
        chk(r1 == 8'hC4, "R9 next block written", int'(r1), 'hC4);
        page_cmd(1'b0, a0, a1);
        wr_one(8'h7F, 8'h3C, a0);
        chk(a0 == 1'b1, "R9 same offset page 0 open", int'(a0), 1);
        wp = 4'b0000;
    endtask

    task automatic t_abort;
        logic a;
        logic [7:0] r0;
        b_start;
        b_wr(mem_sel(1'b0), a);
        b_wr(8'h10, a);
        b_start;
        chk(sda_oe == 1'b0, "R10 start releases line", int'(sda_oe), 0);
        b_wr(mem_sel(1'b1), a);
        b_rd(1'b0, r0);
        b_stop;
        chk(r0 == 8'h5A, "R10 pointer kept across restart", int'(r0), 'h5A);
        b_start;
        b_wr(mem_sel(1'b0), a);
        b_stop;
        chk(sda_oe == 1'b0, "R10 stop returns idle", int'(sda_oe), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wt(5);
        t_reset;
        rst_n = 1'b1;
        wt(5);
        t_reset;
        t_slots;
        t_write_read;
        t_wrap;
        t_pages;
        t_protect;
        t_abort;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule